// File: doc/BRIEF.md
# Delta-Sigma Decimation Filter with Fast-Settling Start

This block turns the 1-bit output of a delta-sigma modulator into signed multi-bit conversion results. Each modulator clock brings one bit, which counts as +1 for a 1 and -1 for a 0. A 3-bit select picks the oversampling ratio. One result comes out for every OSR bits taken in, together with a one-cycle ready strobe.

Two filter paths watch the bitstream at the same time. The first is a plain first-order sinc accumulator, which settles within a single conversion. The second is a third-order sinc (CIC) decimator. For ratios above 1024, that decimator runs at 1024 and a first-order averager sums its results over the rest of the conversion. After a reset, a ratio change, or a stop of the run input, the first two results come from the first-order path. All later results come from the third-order path. Both paths are scaled so that a constant input gives the same output magnitude whichever path produced it and at every ratio.

Top module: `dsm_decim`

## Requirements
- R1: `osr_sel` value k selects an oversampling ratio of 128·2^k, so codes 0 to 7 give 128, 256, 512, 1024, 2048, 4096, 8192 and 16384.
- R2: Each clock edge with `run` high and `osr_sel` unchanged from the previous cycle takes in one bit. On the edge that takes in the OSR-th bit of a conversion, `drdy` is high for exactly one cycle and `data_out` is updated. At all other times `data_out` holds its value.
- R3: The first two results after a restart are the plain sum of that conversion's OSR mapped bits, scaled by 2^24/OSR.
- R4: From the third result on, with OSR ≤ 1024, each result is the third-order sinc response at the selected ratio, scaled by 2^24/OSR³. That response is the sum over the latest 3·OSR−2 bits, weighted by the triple boxcar convolution.
- R5: From the third result on, with OSR > 1024, each result is the sum of the OSR/1024 third-order sinc results at ratio 1024 that fall inside the conversion, scaled by 2^24/(OSR·1024²).
- R6: A constant stream of ones gives +16777216 (2^24) on both paths and at every ratio. A constant stream of zeros gives −16777216. No result ever goes outside ±2^24.
- R7: On an edge where `osr_sel` differs from its value in the previous cycle, the bit is discarded and all filter state is cleared. No strobe follows that edge, and the block restarts with the first-order path.
- R8: While `run` is low, no bits are taken in and no strobe is raised, and `data_out` keeps its last value. When `run` returns high, the block restarts with the first-order path.
- R9: During synchronous active-low reset, `drdy` is 0 and `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High to convert; low clears and idles the filters |
| bit_in | input | 1 | Modulator bitstream (1 → +1, 0 → −1) |
| osr_sel | input | 3 | Oversampling ratio select, 128·2^osr_sel |
| data_out | output | 32 | Signed result, full scale ±2^24 |
| drdy | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result is due on the very edge that takes in the OSR-th bit counted from the last clear. A discarded ratio-change edge or idle cycles do not count toward that total, and no further register sits between the filters and the outputs. The bench drives each bit on the falling edge and reads the outputs 1 ns after the rising edge that took that bit in. It therefore checks that the strobe is absent on bits 1 to OSR−1 and present on bit OSR, and reads the data at that same point. The expected third-order values at ratio 128 come from a direct weighted sum over the recorded bits.

// File: rtl/dsm_decim_pkg.sv
// Shared definitions for the decimation filter: the path select type and
// the scaling helper used to bring every path to the same full scale.
package dsm_decim_pkg;

    localparam int NORM_W = 64;

    typedef enum logic {
        PATH_FAST  = 1'b0,
        PATH_SINC3 = 1'b1
    } path_e;

    // Rescales a raw result whose full scale is 2^raw_log2 to full scale 2^fs_log2.
    function automatic logic signed [NORM_W-1:0] norm_fs(
        input logic signed [NORM_W-1:0] raw,
        input int                       raw_log2,
        input int                       fs_log2
    );
        if (raw_log2 >= fs_log2) return raw >>> (raw_log2 - fs_log2);
        else                     return raw <<< (fs_log2 - raw_log2);
    endfunction

endpackage

// File: rtl/dsm_decim_ctrl.sv
// Sequencing for the decimation filter. Counts bits within a conversion,
// marks the sinc3 decimation points and the conversion end, and keeps the
// fast-settling result count. Assumes osr_sel changes are detected against
// the previous cycle's value; such an edge, or run low, is a clear.
module dsm_decim_ctrl
    import dsm_decim_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int BASE_LOG2   = 7,
    parameter int S3_CAP_LOG2 = 10,
    parameter int FAST_CONVS  = 2,
    parameter int LOG_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] osr_sel,
    output logic             clear,
    output logic             consume,
    output logic             s3_dec,
    output logic             conv_end,
    output path_e            path_sel,
    output logic [LOG_W-1:0] log2_osr,
    output logic [LOG_W-1:0] log2_s3
);
    localparam int MAX_LOG2 = BASE_LOG2 + (1 << SEL_W) - 1;
    localparam int CNT_W    = MAX_LOG2 + 1;
    localparam int FC_W     = $clog2(FAST_CONVS + 1);

    logic [SEL_W-1:0] osr_q;
    logic [CNT_W-1:0] cnt;
    logic [FC_W-1:0]  fast_done;
    logic [CNT_W-1:0] osr_last;
    logic [CNT_W-1:0] s3_mask;

    // Ratio decode, decimation marks and path choice.
    always_comb begin
        log2_osr = LOG_W'(BASE_LOG2) + LOG_W'(osr_q);
        log2_s3  = (log2_osr > LOG_W'(S3_CAP_LOG2)) ? LOG_W'(S3_CAP_LOG2) : log2_osr;
        osr_last = (CNT_W'(1) << log2_osr) - CNT_W'(1);
        s3_mask  = (CNT_W'(1) << log2_s3) - CNT_W'(1);
        clear    = !run || (osr_sel != osr_q);
        consume  = !clear;
        conv_end = consume && (cnt == osr_last);
        s3_dec   = consume && ((cnt & s3_mask) == s3_mask);
        path_sel = (fast_done < FC_W'(FAST_CONVS)) ? PATH_FAST : PATH_SINC3;
    end

    // Bit counter, ratio history and fast-settling result count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osr_q     <= osr_sel;
            cnt       <= '0;
            fast_done <= '0;
        end else begin
            osr_q <= osr_sel;
            if (clear) begin
                cnt       <= '0;
                fast_done <= '0;
            end else if (conv_end) begin
                cnt <= '0;
                if (fast_done < FC_W'(FAST_CONVS)) fast_done <= fast_done + FC_W'(1);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/dsm_sinc1.sv
// Fast-settling first-order sinc path: sums the mapped bits of one
// conversion. The sum including the current bit is available on the
// conversion-end cycle. Assumes the accumulator is wide enough for the
// largest ratio plus sign.
module dsm_sinc1 #(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    consume,
    input  logic                    conv_end,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] sum
);
    logic signed [ACC_W-1:0] acc;

    // Running sum including the present bit.
    always_comb sum = acc + (bit_in ? ACC_W'(1) : {ACC_W{1'b1}});

    // Accumulate within a conversion; empty at its end or on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (conv_end)   acc <= '0;
        else if (consume)    acc <= sum;
    end
endmodule

// File: rtl/dsm_sinc3.sv
// Third-order CIC decimator: three integrators at the bit rate and three
// differentiators at the decimation points. Arithmetic wraps modulo
// 2^ACC_W, which must exceed 3*log2(ratio)+1 bits.
module dsm_sinc3 #(
    parameter int ACC_W = 44
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    consume,
    input  logic                    s3_dec,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] d3
);
    logic signed [ACC_W-1:0] i1, i2, i3, z1, z2, z3;
    logic signed [ACC_W-1:0] i1_n, i2_n, i3_n, d1, d2;

    // Integrator chain and differentiator chain, both without added latency.
    always_comb begin
        i1_n = i1 + (bit_in ? ACC_W'(1) : {ACC_W{1'b1}});
        i2_n = i2 + i1_n;
        i3_n = i3 + i2_n;
        d1   = i3_n - z1;
        d2   = d1 - z2;
        d3   = d2 - z3;
    end

    // State update: integrate every taken bit, store delays at decimation points.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            i1 <= '0; i2 <= '0; i3 <= '0;
            z1 <= '0; z2 <= '0; z3 <= '0;
        end else if (consume) begin
            i1 <= i1_n; i2 <= i2_n; i3 <= i3_n;
            if (s3_dec) begin
                z1 <= i3_n; z2 <= d1; z3 <= d2;
            end
        end
    end
endmodule

// File: rtl/dsm_avg.sv
// First-order averager after the sinc3 decimator: sums the sinc3 results
// of one conversion. With a single decimation per conversion it passes
// the sinc3 result through unchanged.
module dsm_avg #(
    parameter int ACC_W = 44
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    s3_dec,
    input  logic                    conv_end,
    input  logic signed [ACC_W-1:0] d3,
    output logic signed [ACC_W-1:0] total
);
    logic signed [ACC_W-1:0] acc;

    // Sum of earlier sinc3 results of this conversion plus the present one.
    always_comb total = acc + d3;

    // Collect sinc3 results; restart at each conversion end or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (conv_end)   acc <= '0;
        else if (s3_dec)     acc <= total;
    end
endmodule

// File: rtl/dsm_decim.sv
// Delta-sigma decimation filter top. Runs the fast-settling sinc1 path and
// the sinc3 (+ averager) path side by side, scales each to full scale
// 2^FS_LOG2 and registers the selected one with a one-cycle ready strobe.
// Assumes one modulator bit per clock.
module dsm_decim
    import dsm_decim_pkg::*;
#(
    parameter int OUT_W       = 32,
    parameter int FS_LOG2     = 24,
    parameter int SEL_W       = 3,
    parameter int BASE_LOG2   = 7,
    parameter int S3_CAP_LOG2 = 10,
    parameter int FAST_CONVS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bit_in,
    input  logic [SEL_W-1:0] osr_sel,
    output logic [OUT_W-1:0] data_out,
    output logic             drdy
);
    localparam int MAX_LOG2 = BASE_LOG2 + (1 << SEL_W) - 1;
    localparam int LOG_W    = $clog2(MAX_LOG2 + 1);
    localparam int S1_W     = MAX_LOG2 + 2;
    localparam int S3_W     = 3 * MAX_LOG2 + 2;

    logic                    clear, consume, s3_dec, conv_end;
    path_e                   path_sel;
    logic [LOG_W-1:0]        log2_osr, log2_s3;
    logic signed [S1_W-1:0]  s1_sum;
    logic signed [S3_W-1:0]  s3_d3, s3_total;
    logic signed [NORM_W-1:0] fast_n, slow_n;
    int                      slow_log2;

    dsm_decim_ctrl #(
        .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .S3_CAP_LOG2(S3_CAP_LOG2),
        .FAST_CONVS(FAST_CONVS), .LOG_W(LOG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run), .osr_sel(osr_sel),
        .clear(clear), .consume(consume), .s3_dec(s3_dec), .conv_end(conv_end),
        .path_sel(path_sel), .log2_osr(log2_osr), .log2_s3(log2_s3)
    );

    dsm_sinc1 #(.ACC_W(S1_W)) u_sinc1 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .consume(consume),
        .conv_end(conv_end), .bit_in(bit_in), .sum(s1_sum)
    );

    dsm_sinc3 #(.ACC_W(S3_W)) u_sinc3 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .consume(consume),
        .s3_dec(s3_dec), .bit_in(bit_in), .d3(s3_d3)
    );

    dsm_avg #(.ACC_W(S3_W)) u_avg (
        .clk(clk), .rst_n(rst_n), .clear(clear), .s3_dec(s3_dec),
        .conv_end(conv_end), .d3(s3_d3), .total(s3_total)
    );

    // Scale both paths to the common full scale.
    always_comb begin
        slow_log2 = 3 * int'(log2_s3) + int'(log2_osr) - int'(log2_s3);
        fast_n = norm_fs({{(NORM_W-S1_W){s1_sum[S1_W-1]}}, s1_sum}, int'(log2_osr), FS_LOG2);
        slow_n = norm_fs({{(NORM_W-S3_W){s3_total[S3_W-1]}}, s3_total}, slow_log2, FS_LOG2);
    end

    // Output register: capture the selected path at each conversion end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            drdy     <= 1'b0;
        end else begin
            drdy <= conv_end;
            if (conv_end) data_out <= (path_sel == PATH_FAST) ? OUT_W'(fast_n) : OUT_W'(slow_n);
        end
    end
endmodule

// File: rtl/dsm_decim_chk.sv
// Property checker for dsm_decim, bound to every instance. Keeps its own
// count of taken bits to know where each strobe is due.
module dsm_decim_chk #(
    parameter int OUT_W     = 32,
    parameter int FS_LOG2   = 24,
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [SEL_W-1:0] osr_sel,
    input logic [OUT_W-1:0] data_out,
    input logic             drdy
);
    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);
    localparam logic signed [OUT_W-1:0] FS_POS = OUT_W'(1) << FS_LOG2;
    localparam logic signed [OUT_W-1:0] FS_NEG = -FS_POS;

    logic [SEL_W-1:0] sel_prev;
    logic [CNT_W-1:0] seen, len_m1;
    logic             restart, due;

    always_comb begin
        restart = !run || (osr_sel != sel_prev);
        len_m1  = (CNT_W'(1) << (BASE_LOG2 + int'(osr_sel))) - CNT_W'(1);
    end

    // Independent bit count since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev <= osr_sel;
            seen     <= '0;
            due      <= 1'b0;
        end else begin
            sel_prev <= osr_sel;
            due      <= !restart && (seen == len_m1);
            seen     <= (restart || seen == len_m1) ? '0 : seen + CNT_W'(1);
        end
    end

    a_r2_strobe_when_due: assert property (@(posedge clk) disable iff (!rst_n) drdy |-> due);
    a_r2_due_gives_strobe: assert property (@(posedge clk) disable iff (!rst_n) due |-> drdy);
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n) drdy |=> !drdy);
    a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n) !drdy |-> $stable(data_out));
    a_r6_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |-> ($signed(data_out) <= FS_POS && $signed(data_out) >= FS_NEG));
    a_r7_change_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (osr_sel != sel_prev) |=> !drdy);
    a_r8_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !drdy);
    a_r9_reset_clears: assert property (@(posedge clk) !rst_n |=> (!drdy && data_out == '0));
endmodule

bind dsm_decim dsm_decim_chk #(
    .OUT_W(OUT_W), .FS_LOG2(FS_LOG2), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)
) i_dsm_decim_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .osr_sel(osr_sel),
    .data_out(data_out), .drdy(drdy)
);

// File: tb/test_dsm_decim.sv
`timescale 1ns/1ps
// Directed bench for dsm_decim: one task per scenario.
module test_dsm_decim;
    localparam int  FS   = 1 << 24;
    localparam int  NFIR = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        bit_in = 1'b0;
    logic [2:0]  osr_sel = 3'd0;
    logic [31:0] data_out;
    logic        drdy;

    int tests = 0;
    int fails = 0;
    int nfed  = 0;
    bit hist [0:1023];
    longint h3 [0:3*NFIR-3];

    dsm_decim i_dsm_decim (
        .clk(clk), .rst_n(rst_n), .run(run), .bit_in(bit_in),
        .osr_sel(osr_sel), .data_out(data_out), .drdy(drdy)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bit value of a test pattern: 0 zeros, 1 ones, 2 alternating, 3 ones for 3/4 then zeros.
    function automatic bit pat(input int mode, input int k, input int n);
        case (mode)
            0: return 1'b0;
            1: return 1'b1;
            2: return (k % 2) == 0;
            default: return k < (n * 3) / 4;
        endcase
    endfunction

    task automatic step(input bit b);
        @(negedge clk);
        run = 1'b1;
        bit_in = b;
        @(posedge clk);
        #1;
        if (nfed < 1024) hist[nfed] = b;
        nfed++;
    endtask

    // One conversion of n bits; checks strobe timing (R2) and returns the data.
    task automatic conv(input int n, input int mode, output longint got);
        bit early = 1'b0;
        for (int k = 0; k < n; k++) begin
            step(pat(mode, k, n));
            if (k < n - 1 && drdy) early = 1'b1;
        end
        chk(!early, "R2", "strobe before last bit", early, 0);
        chk(drdy == 1'b1, "R2", "strobe on last bit", drdy, 1);
        got = longint'($signed(data_out));
    endtask

    task automatic do_reset(input logic [2:0] sel);
        @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        osr_sel = sel;
        repeat (4) @(posedge clk);
        #1;
        chk(drdy == 1'b0 && data_out == 32'd0, "R9", "outputs in reset", longint'(data_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        nfed = 0;
    endtask

    // Weighted sum of recorded bits for the m-th sinc3 result at ratio 128 (R4).
    function automatic longint fir3(input int m);
        longint s = 0;
        for (int k = 0; k <= 3 * NFIR - 3; k++) begin
            int j = m * NFIR - 1 - k;
            if (j >= 0) s += hist[j] ? h3[k] : -h3[k];
        end
        return s;
    endfunction

    task automatic t_fast_then_sinc3;
        longint got;
        do_reset(3'd0);
        conv(128, 3, got);
        chk(got == FS / 2, "R3", "first fast result, 3/4 density", got, FS / 2);
        conv(128, 0, got);
        chk(got == -FS, "R3", "second fast result, zeros", got, -FS);
        conv(128, 1, got);
        chk(got == fir3(3) * 8, "R4", "third result from sinc3", got, fir3(3) * 8);
        conv(128, 2, got);
        chk(got == fir3(4) * 8, "R4", "fourth result from sinc3", got, fir3(4) * 8);
        step(1'b1);
        chk(drdy == 1'b0, "R2", "strobe one cycle wide", drdy, 0);
    endtask

    task automatic t_ratio_scale(input logic [2:0] sel, input int mode, input longint exp, input string req);
        longint got;
        do_reset(sel);
        for (int c = 0; c < 3; c++) begin
            conv(128 << sel, mode, got);
            chk(got == exp, req, $sformatf("sel %0d result %0d", sel, c + 1), got, exp);
        end
    endtask

    task automatic t_osr_change;
        longint got;
        do_reset(3'd0);
        for (int k = 0; k < 64; k++) step(1'b1);
        @(negedge clk);
        osr_sel = 3'd1;
        bit_in = 1'b1;
        @(posedge clk);
        #1;
        chk(drdy == 1'b0, "R7", "no strobe on ratio change", drdy, 0);
        nfed = 0;
        conv(256, 3, got);
        chk(got == FS / 2, "R7", "restart with fast path at new ratio", got, FS / 2);
        conv(256, 1, got);
        chk(got == FS, "R6", "ratio 256 full scale", got, FS);
    endtask

    task automatic t_run_low;
        longint got;
        bit strobe = 1'b0, moved = 1'b0;
        do_reset(3'd0);
        conv(128, 1, got);
        chk(got == FS, "R6", "fast ones full scale", got, FS);
        for (int k = 0; k < 100; k++) step(1'b0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            run = 1'b0;
            bit_in = 1'b0;
            @(posedge clk);
            #1;
            if (drdy) strobe = 1'b1;
            if ($signed(data_out) != FS) moved = 1'b1;
        end
        chk(!strobe, "R8", "no strobe while idle", strobe, 0);
        chk(!moved, "R8", "data kept while idle", moved, 0);
        nfed = 0;
        conv(128, 0, got);
        chk(got == -FS, "R8", "first result after idle", got, -FS);
        conv(128, 3, got);
        chk(got == FS / 2, "R8", "second result after idle still fast", got, FS / 2);
    endtask

    initial begin
        for (int k = 0; k <= 3 * NFIR - 3; k++) h3[k] = 0;
        for (int a = 0; a < NFIR; a++)
            for (int b = 0; b < NFIR; b++)
                for (int c = 0; c < NFIR; c++) h3[a + b + c]++;
        t_fast_then_sinc3();
        t_ratio_scale(3'd1, 1, FS, "R1");
        t_ratio_scale(3'd2, 1, FS, "R6");
        t_ratio_scale(3'd3, 0, -FS, "R6");
        t_ratio_scale(3'd4, 2, 0, "R5");
        t_ratio_scale(3'd5, 0, -FS, "R5");
        t_ratio_scale(3'd7, 1, FS, "R1");
        t_osr_change();
        t_run_low();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule